// File: doc/BRIEF.md
# Framed Serial Display-Write Decoder

This block sits behind a byte-wide serial receiver (19200 baud, 8 data bits, no parity, one stop bit) and turns a stream of received bytes into writes on a small display memory. Each received byte arrives with a one-cycle valid strobe. Bytes are grouped into packets. A packet is a start byte, then a header byte, then a payload whose length the header gives, then an end byte. The header carries a type code in its upper nybble and the payload length in its lower nybble.

A packet of the write type (type 9) uses its first payload byte as a start address. Every later payload byte is written to the next address in turn. The display memory holds 48 bytes, arranged as three multiplex sets of 16 bytes based at 0x00, 0x10 and 0x20. A common write uses header 0x99: one address byte and eight data bytes. Packets of any other type are parsed to their end and discarded.

The block reports each properly closed packet on a one-cycle done flag. A packet whose closing position holds the wrong byte raises a one-cycle framing-error flag instead, and the block then goes back to looking for a start byte.

Top module: `disp_frame_decoder`

## Requirements
- R1: While looking for a packet, every received byte other than 0x02 is dropped and causes no write and no flag.
- R2: After 0x02 the next byte is the header: bits 7:4 are the type and bits 3:0 the payload count N. Exactly N payload bytes are consumed, whatever their values (0x03 included), before the closing byte is examined.
- R3: In a type-9 packet the first payload byte is the start address A. Payload byte k (k ≥ 1) is written to address A+k-1: memWrEn is high for exactly one cycle, in the cycle after that byte's valid strobe, with memAddr and memData set.
- R4: A write whose address is 0x30 or higher, whether as a start address or reached by stepping, is suppressed. The stepping does not wrap from 0xFF to 0x00. The in-range bytes of the same packet are still written.
- R5: A packet of any type other than 9 is consumed in full and produces no write.
- R6: When the byte in the closing position is 0x03, pktDone is high for one cycle in the cycle after that byte's strobe.
- R7: When the byte in the closing position is not 0x03, frameErr is high for one cycle in the cycle after it, and the writes already made stay in place. That byte is consumed even if it is 0x02, so it never begins a new packet, and the block returns to looking for 0x02.
- R8: Cycles without a valid strobe change nothing, so idle gaps of any length between bytes are allowed.
- R9: During and after reset all outputs are low and the block is looking for a start byte.
- R10: A header with N = 0 is followed directly by the closing byte. A type-9 packet with N = 1 carries only an address and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received-byte strobe, one cycle per byte |
| rxData | input | 8 | Received byte, valid with rxValid |
| memWrEn | output | 1 | Display-memory write enable |
| memAddr | output | 6 | Display-memory write address |
| memData | output | 8 | Display-memory write data |
| pktDone | output | 1 | Pulse: packet closed correctly |
| frameErr | output | 1 | Pulse: wrong byte in the closing position |

## Verification
The assertions check on every cycle that no write leaves the 48-byte range, that writes in successive cycles use successive addresses and carry the byte just received, that done and error never appear together, that done follows only a 0x03 byte, that idle cycles leave the parser unchanged, and that a non-start byte keeps the parser in its hunting state. Only the bench's scenarios can show that the right bytes reach the right addresses over a whole packet. The same holds for whether the header length is obeyed when the payload holds 0x03, for whether a wrong closing byte of 0x02 is kept from starting a packet, and for whether addresses near 0xFF are kept from wrapping into memory.

// File: rtl/disp_frame_pkg.sv
package disp_frame_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_HEADER,
    ST_PAYLOAD,
    ST_TAIL
  } rxState_e;

  typedef struct packed {
    logic loadAddr;
    logic writeData;
    logic endOk;
    logic endBad;
  } ctrlStrobe_t;
endpackage

// File: rtl/disp_frame_ctrl.sv
module disp_frame_ctrl
  import disp_frame_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          LEN_W      = 4,
  parameter logic [7:0]  START_BYTE = 8'h02,
  parameter logic [7:0]  END_BYTE   = 8'h03,
  parameter logic [3:0]  WR_TYPE    = 4'h9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output ctrlStrobe_t       strobe
);
  rxState_e         state;
  logic [LEN_W-1:0] remCnt;
  logic             isWrite;
  logic             firstPl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_HUNT;
      remCnt  <= '0;
      isWrite <= 1'b0;
      firstPl <= 1'b0;
    end else if (rxValid) begin
      case (state)
        ST_HUNT: begin
          if (rxData == START_BYTE) state <= ST_HEADER;
        end
        ST_HEADER: begin
          isWrite <= (rxData[DATA_W-1 -: 4] == WR_TYPE);
          remCnt  <= rxData[LEN_W-1:0];
          firstPl <= 1'b1;
          state   <= (rxData[LEN_W-1:0] == '0) ? ST_TAIL : ST_PAYLOAD;
        end
        ST_PAYLOAD: begin
          firstPl <= 1'b0;
          remCnt  <= remCnt - 1'b1;
          if (remCnt == LEN_W'(1)) state <= ST_TAIL;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  always_comb begin
    strobe.loadAddr  = rxValid && (state == ST_PAYLOAD) && isWrite && firstPl;
    strobe.writeData = rxValid && (state == ST_PAYLOAD) && isWrite && !firstPl;
    strobe.endOk     = rxValid && (state == ST_TAIL) && (rxData == END_BYTE);
    strobe.endBad    = rxValid && (state == ST_TAIL) && (rxData != END_BYTE);
  end

  // R1: a non-start byte keeps the parser hunting
  a_r1_hunt_discard: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HUNT && rxValid && rxData != START_BYTE) |=> (state == ST_HUNT));

  // R8: idle cycles leave the parser untouched
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> ($stable(state) && $stable(remCnt) && $stable(firstPl)));

  // R2: payload state always has bytes left to consume
  a_r2_payload_count: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAYLOAD) |-> (remCnt != '0));

  // R10: zero-length header goes straight to the closing byte
  a_r10_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HEADER && rxValid && rxData[LEN_W-1:0] == '0) |=> (state == ST_TAIL));
endmodule

// File: rtl/disp_frame_dp.sv
module disp_frame_dp
  import disp_frame_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MEM_DEPTH = 48,
  localparam int ADDR_W   = $clog2(MEM_DEPTH),
  localparam int PTR_W    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rxData,
  input  ctrlStrobe_t       strobe,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              pktDone,
  output logic              frameErr
);
  // one spare bit so stepping past 0xFF never wraps back into memory
  logic [PTR_W-1:0] wrPtr;
  logic             inRange;

  assign inRange = (wrPtr < PTR_W'(MEM_DEPTH));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      memWrEn  <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      pktDone  <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      memWrEn  <= strobe.writeData && inRange;
      pktDone  <= strobe.endOk;
      frameErr <= strobe.endBad;
      if (strobe.loadAddr) begin
        wrPtr <= {1'b0, rxData};
      end else if (strobe.writeData) begin
        if (!wrPtr[PTR_W-1]) wrPtr <= wrPtr + 1'b1;
        if (inRange) begin
          memAddr <= wrPtr[ADDR_W-1:0];
          memData <= rxData;
        end
      end
    end
  end

  // R4: no write leaves the memory range
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (int'(memAddr) < MEM_DEPTH));

  // R3: back-to-back writes step the address by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> (memAddr == $past(memAddr) + 1'b1));

  // R3: written data is the byte received one cycle earlier
  a_r3_data: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memData == $past(rxData)));

  // R6 / R7: a packet ends one way only
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(pktDone && frameErr));
endmodule

// File: rtl/disp_frame_decoder.sv
module disp_frame_decoder
  import disp_frame_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          MEM_DEPTH  = 48,
  parameter logic [7:0]  START_BYTE = 8'h02,
  parameter logic [7:0]  END_BYTE   = 8'h03,
  parameter logic [3:0]  WR_TYPE    = 4'h9,
  localparam int ADDR_W = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              pktDone,
  output logic              frameErr
);
  ctrlStrobe_t strobe;

  disp_frame_ctrl #(
    .DATA_W    (DATA_W),
    .LEN_W     (4),
    .START_BYTE(START_BYTE),
    .END_BYTE  (END_BYTE),
    .WR_TYPE   (WR_TYPE)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rxValid(rxValid),
    .rxData (rxData),
    .strobe (strobe)
  );

  disp_frame_dp #(
    .DATA_W   (DATA_W),
    .MEM_DEPTH(MEM_DEPTH)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .rxData  (rxData),
    .strobe  (strobe),
    .memWrEn (memWrEn),
    .memAddr (memAddr),
    .memData (memData),
    .pktDone (pktDone),
    .frameErr(frameErr)
  );

  // R6: done only follows a received closing byte
  a_r6_done_source: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> ($past(rxValid) && $past(rxData) == END_BYTE));

  // R8: nothing is reported without a byte the cycle before
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> (!memWrEn && !pktDone && !frameErr));
endmodule

// File: tb/disp_frame_decoder_tb_top.sv
module disp_frame_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic       memWrEn;
  logic [5:0] memAddr;
  logic [7:0] memData;
  logic       pktDone;
  logic       frameErr;

  int checks = 0;
  int fails = 0;
  int doneSeen = 0;
  int errSeen = 0;
  int gapMax = 0;
  string curTag = "R3";

  logic [13:0] expQ[$];
  logic [7:0]  plBuf[16];

  always #10 clk = ~clk;

  disp_frame_decoder dut_i (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .pktDone(pktDone), .frameErr(frameErr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: every write must match the next expected one
  always @(negedge clk) begin : monitor
    logic [13:0] e;
    if (rstN) begin
      if (pktDone) doneSeen++;
      if (frameErr) errSeen++;
      if (memWrEn) begin
        if (expQ.size() == 0) begin
          chk(1'b0, curTag, "unexpected write", {memAddr, memData}, 0);
        end else begin
          e = expQ.pop_front();
          chk({memAddr, memData} === e, curTag, "write addr/data",
              {memAddr, memData}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    finishRun();
  end

  task automatic sendByte(input logic [7:0] b);
    int g;
    rxValid = 1'b1;
    rxData  = b;
    @(negedge clk);
    rxValid = 1'b0;
    g = (gapMax == 0) ? 0 : int'($urandom % (gapMax + 1));
    for (int i = 0; i < g; i++) @(negedge clk);
  endtask

  // expected writes for a packet, from R3/R4/R5/R10
  task automatic addExpected(input logic [7:0] hdr);
    int n;
    int a;
    n = int'(hdr[3:0]);
    if (hdr[7:4] == 4'h9 && n >= 1) begin
      for (int k = 1; k < n; k++) begin
        a = int'(plBuf[0]) + k - 1;
        if (a < 48) expQ.push_back({a[5:0], plBuf[k]});
      end
    end
  endtask

  task automatic sendPacket(input logic [7:0] hdr, input logic [7:0] endB,
                            input string tag);
    int d0;
    int e0;
    curTag = tag;
    d0 = doneSeen;
    e0 = errSeen;
    addExpected(hdr);
    sendByte(8'h02);
    sendByte(hdr);
    for (int k = 0; k < int'(hdr[3:0]); k++) sendByte(plBuf[k]);
    sendByte(endB);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, tag, "writes missing", expQ.size(), 0);
    expQ.delete();
    chk(doneSeen - d0 == ((endB == 8'h03) ? 1 : 0), (endB == 8'h03) ? "R6" : "R7",
        "done pulses", doneSeen - d0, (endB == 8'h03) ? 1 : 0);
    chk(errSeen - e0 == ((endB == 8'h03) ? 0 : 1), "R7", "error pulses",
        errSeen - e0, (endB == 8'h03) ? 0 : 1);
  endtask

  task automatic sendJunk(input int n);
    logic [7:0] b;
    int d0;
    int e0;
    curTag = "R1";
    d0 = doneSeen;
    e0 = errSeen;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      if (b == 8'h02) b = 8'h03;
      sendByte(b);
    end
    repeat (3) @(negedge clk);
    chk(doneSeen == d0 && errSeen == e0, "R1", "flags after junk",
        doneSeen - d0 + errSeen - e0, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rxValid = 1'b0;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    chk({memWrEn, pktDone, frameErr} == 3'b000, "R9", "outputs in reset",
        {memWrEn, pktDone, frameErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({memWrEn, pktDone, frameErr} == 3'b000, "R9", "outputs after reset",
        {memWrEn, pktDone, frameErr}, 0);

    // directed: hunting discards, including 0x03 and 0x99
    gapMax = 0;
    curTag = "R1";
    sendByte(8'h03);
    sendByte(8'h99);
    sendByte(8'h10);
    sendJunk(12);

    // typical write: header 0x99 to set 1, offset 0
    plBuf[0] = 8'h10;
    for (int k = 1; k < 9; k++) plBuf[k] = 8'(8'hA0 + k);
    sendPacket(8'h99, 8'h03, "R3");

    // payload full of 0x03 must not end the packet early
    plBuf[0] = 8'h28;
    for (int k = 1; k < 9; k++) plBuf[k] = 8'h03;
    sendPacket(8'h99, 8'h03, "R2");

    // partial overrun of the top of memory
    plBuf[0] = 8'h2C;
    for (int k = 1; k < 9; k++) plBuf[k] = 8'(8'h50 + k);
    sendPacket(8'h99, 8'h03, "R4");

    // start near 0xFF: stepping must not wrap into memory
    plBuf[0] = 8'hFA;
    for (int k = 1; k < 15; k++) plBuf[k] = 8'(8'h60 + k);
    sendPacket(8'h9F, 8'h03, "R4");

    // zero-length write and address-only write
    sendPacket(8'h90, 8'h03, "R10");
    plBuf[0] = 8'h05;
    sendPacket(8'h91, 8'h03, "R10");

    // other type: no writes
    plBuf[0] = 8'h00; plBuf[1] = 8'h11; plBuf[2] = 8'h22;
    sendPacket(8'h53, 8'h03, "R5");

    // bad closing byte: earlier writes stand, error flagged
    plBuf[0] = 8'h20; plBuf[1] = 8'h77; plBuf[2] = 8'h88;
    sendPacket(8'h93, 8'hEE, "R7");

    // bad closing byte equal to 0x02 must not open a packet
    plBuf[0] = 8'h00; plBuf[1] = 8'h12;
    sendPacket(8'h92, 8'h02, "R7");
    begin
      int d0;
      d0 = doneSeen;
      curTag = "R7";
      sendByte(8'h91);
      sendByte(8'h05);
      sendByte(8'h03);
      repeat (3) @(negedge clk);
      chk(doneSeen == d0, "R7", "0x02 in closing slot started a packet",
          doneSeen - d0, 0);
    end

    // constrained random packets with idle gaps
    gapMax = 3;
    for (int p = 0; p < 60; p++) begin
      logic [7:0] hdr;
      logic [7:0] endB;
      hdr[7:4] = ($urandom % 3 == 0) ? 4'($urandom) : 4'h9;
      hdr[3:0] = 4'($urandom);
      for (int k = 0; k < 16; k++) plBuf[k] = 8'($urandom);
      plBuf[0] = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 64);
      endB = ($urandom % 8 == 0) ? 8'($urandom) : 8'h03;
      sendPacket(hdr, endB, (hdr[7:4] == 4'h9) ? "R8" : "R5");
      if ($urandom % 4 == 0) sendJunk(1 + int'($urandom % 4));
    end

    finishRun();
  end
endmodule